// File: doc/BRIEF.md
# Message Buffer Time Stamp Unit

This block sits inside a serial bus message controller and records when each message finished on the bus. A 16-bit counter advances once per bus bit-time tick, wraps past its top value with no warning, and is held at zero while the controller is in init mode. When the controller reports a completed frame and marks it as good, the unit copies the counter into the stamp register of the one buffer that the controller names as active. The buffer is picked by a direction flag (receive or transmit) and an index. Three receive and three transmit buffers are modelled.

Software only reads the stamps, one byte at a time, through a combinational read port. A receive stamp can be read once it has been captured. A transmit stamp can be read only while its buffer reports empty and that buffer is the one chosen by the transmit-buffer select. A read that is not allowed returns zero. Writes from the CPU reach the block but never change a stamp.

Top module: `msg_stamp_unit`

## Requirements
- R1: The counter goes up by exactly one on each clock where `bit_tick` is high and `init_mode` is low. It holds its value on every other clock outside init mode.
- R2: After 0xFFFF the counter returns to 0x0000, and nothing reports the wrap.
- R3: On any clock where `init_mode` is high, the counter becomes zero.
- R4: On a clock where `eof_pulse`, `eof_ok` and `stamp_en` are all high, the stamp of the buffer named by `act_is_tx` (1 = transmit, 0 = receive) and `act_idx` receives the counter value. From the next clock on, that stamp reads back as valid. No other buffer changes.
- R5: While `stamp_en` is low, no stamp changes, even when a good end of frame is reported.
- R6: An end of frame with `eof_ok` low changes no stamp.
- R7: If a tick and a capture fall on the same clock, the stamp gets the counter value from before that tick.
- R8: With `rd_hi` = 1, `rd_data` returns stamp bits 15..8. With `rd_hi` = 0, it returns bits 7..0.
- R9: A transmit stamp reads as nonzero data only when it has been captured, its bit in `tx_empty` is 1 and its bit in `tx_sel` is 1. In every other case it reads 0.
- R10: A receive stamp reads 0 until its first capture and its stored value after that. After reset, every read returns 0.
- R11: Writes through `cpu_wr_en` and `cpu_wr_data` never change any stamp.
- R12: An active index of 3 captures nothing. A read at index 3 returns 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| bit_tick | input | 1 | One-clock pulse per bus bit time |
| init_mode | input | 1 | High while the controller is in init mode; clears the counter |
| stamp_en | input | 1 | Enables stamp capture |
| eof_pulse | input | 1 | End of frame reached |
| eof_ok | input | 1 | The frame that just ended is good |
| act_is_tx | input | 1 | Direction of the active buffer: 1 = transmit, 0 = receive |
| act_idx | input | 2 | Index of the active buffer |
| tx_empty | input | 3 | Empty flag of each transmit buffer |
| tx_sel | input | 3 | Transmit-buffer select, one bit per buffer |
| cpu_wr_en | input | 1 | CPU write strobe toward the stamp registers (ignored) |
| cpu_wr_data | input | 8 | CPU write data (ignored) |
| rd_is_tx | input | 1 | Read direction: 1 = transmit, 0 = receive |
| rd_idx | input | 2 | Read buffer index |
| rd_hi | input | 1 | 1 = high byte, 0 = low byte |
| rd_data | output | 8 | Selected stamp byte, or 0 when the read is not allowed |

## Verification
The bench goes after the following corner cases:
- **Tick and capture in the same clock.** A design that samples the counter after the increment stores a value one too high.
- **Counter wrap.** A full lap of the counter exposes a design that saturates or drops the top bit. Such a design reads something other than 3 three ticks past the wrap.
- **Blocked ends of frame.** Frames with the enable off, with a bad-frame flag, or aimed at index 3 must leave every stamp untouched. A loose capture decode would overwrite a neighbouring buffer.
- **Transmit read gating.** The empty flags and select bits are swept through their combinations. A design that ignores either one leaks a stale stamp instead of returning zero.
- **Byte order.** A known value of 0x1234 catches swapped bytes.

// File: rtl/msg_stamp_pkg.sv
// Package: shared constants and the buffer direction type for the stamp unit.
// Assumes stamps are a whole number of bytes wide.
package msg_stamp_pkg;
    localparam int STAMP_W_DEF = 16;
    localparam int NUM_RX_DEF  = 3;
    localparam int NUM_TX_DEF  = 3;
    localparam int BYTE_W      = 8;

    typedef enum logic {
        DIR_RX = 1'b0,
        DIR_TX = 1'b1
    } buf_dir_e;
endpackage

// File: rtl/stamp_counter.sv
// Module: stamp_counter
// A free-running bit-time counter. It steps on each tick, wraps silently
// and is cleared while init mode is high.
// Assumes the tick is a single-clock pulse that is already synchronous.
module stamp_counter #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         tick,
    input  logic         init,
    output logic [W-1:0] count
);
    // Counter register: clear on reset or init, else step on tick.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            count <= '0;
        end else if (init) begin
            count <= '0;
        end else if (tick) begin
            count <= count + W'(1);
        end
    end

    assert_init_clear_R3: assert property (@(posedge clk) disable iff (!rst_n)
        init |=> (count == '0));

    assert_tick_step_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (!init && tick) |=> (count == W'($past(count) + W'(1))));

    assert_idle_hold_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (!init && !tick) |=> $stable(count));

    assert_wrap_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (!init && tick && (count == '1)) |=> (count == '0));
endmodule

// File: rtl/stamp_bank.sv
// Module: stamp_bank
// Holds the stamp registers for one direction (receive or transmit).
// Each entry loads the capture value when its strobe is high and sets its
// valid bit. Reset clears both, which stands in for the undefined value.
// Assumes at most one strobe is high on any clock.
module stamp_bank #(
    parameter int N = 3,
    parameter int W = 16
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [N-1:0]        cap_vec,
    input  logic [W-1:0]        cap_value,
    output logic [N-1:0][W-1:0] stamp_q,
    output logic [N-1:0]        valid_q
);
    for (genvar g = 0; g < N; g++) begin : g_entry
        // Entry register: load the stamp and mark it valid on a capture strobe.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                stamp_q[g] <= '0;
                valid_q[g] <= 1'b0;
            end else if (cap_vec[g]) begin
                stamp_q[g] <= cap_value;
                valid_q[g] <= 1'b1;
            end
        end

        assert_entry_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
            !cap_vec[g] |=> ($stable(stamp_q[g]) && $stable(valid_q[g])));

        assert_entry_load_R4: assert property (@(posedge clk) disable iff (!rst_n)
            cap_vec[g] |=> (valid_q[g] && (stamp_q[g] == $past(cap_value))));
    end
endmodule

// File: rtl/stamp_read_port.sv
// Module: stamp_read_port
// The CPU read path. It picks one stamp byte and zeroes reads that are not
// allowed. A receive stamp needs its valid bit. A transmit stamp needs its
// valid bit, its empty flag and its select bit.
// Assumes the high byte is the top BYTE_W bits of the stamp.
module stamp_read_port #(
    parameter int NUM_RX  = 3,
    parameter int NUM_TX  = 3,
    parameter int STAMP_W = 16,
    parameter int IDX_W   = 2,
    parameter int BYTE_W  = 8
) (
    input  logic [NUM_RX-1:0][STAMP_W-1:0] rx_stamp,
    input  logic [NUM_RX-1:0]              rx_valid,
    input  logic [NUM_TX-1:0][STAMP_W-1:0] tx_stamp,
    input  logic [NUM_TX-1:0]              tx_valid,
    input  logic [NUM_TX-1:0]              tx_empty,
    input  logic [NUM_TX-1:0]              tx_sel,
    input  logic                           rd_is_tx,
    input  logic [IDX_W-1:0]               rd_idx,
    input  logic                           rd_hi,
    output logic [BYTE_W-1:0]              rd_data
);
    logic [STAMP_W-1:0] word;
    logic               allowed;

    // Word select and access gate for the addressed buffer.
    always_comb begin
        word    = '0;
        allowed = 1'b0;
        if (rd_is_tx) begin
            for (int i = 0; i < NUM_TX; i++) begin
                if (rd_idx == IDX_W'(i)) begin
                    word    = tx_stamp[i];
                    allowed = tx_valid[i] & tx_empty[i] & tx_sel[i];
                end
            end
        end else begin
            for (int i = 0; i < NUM_RX; i++) begin
                if (rd_idx == IDX_W'(i)) begin
                    word    = rx_stamp[i];
                    allowed = rx_valid[i];
                end
            end
        end
    end

    // Byte lane select; a read that is not allowed returns zero.
    always_comb begin
        if (!allowed) begin
            rd_data = '0;
        end else if (rd_hi) begin
            rd_data = word[STAMP_W-1 -: BYTE_W];
        end else begin
            rd_data = word[BYTE_W-1:0];
        end
    end
endmodule

// File: rtl/msg_stamp_unit.sv
// Module: msg_stamp_unit (top)
// The time stamp unit of a bus message controller. On a good end of frame,
// with stamping enabled, it loads the bit-time counter into the active
// buffer's stamp. Stamps are read one byte at a time through a gated port.
// Assumes eof_pulse lasts one clock and that the active-buffer fields are
// stable on that clock.
module msg_stamp_unit #(
    parameter int STAMP_W = msg_stamp_pkg::STAMP_W_DEF,
    parameter int NUM_RX  = msg_stamp_pkg::NUM_RX_DEF,
    parameter int NUM_TX  = msg_stamp_pkg::NUM_TX_DEF,
    parameter int IDX_W   = 2
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      bit_tick,
    input  logic                      init_mode,
    input  logic                      stamp_en,
    input  logic                      eof_pulse,
    input  logic                      eof_ok,
    input  logic                      act_is_tx,
    input  logic [IDX_W-1:0]          act_idx,
    input  logic [NUM_TX-1:0]         tx_empty,
    input  logic [NUM_TX-1:0]         tx_sel,
    input  logic                      cpu_wr_en,
    input  logic [msg_stamp_pkg::BYTE_W-1:0] cpu_wr_data,
    input  logic                      rd_is_tx,
    input  logic [IDX_W-1:0]          rd_idx,
    input  logic                      rd_hi,
    output logic [msg_stamp_pkg::BYTE_W-1:0] rd_data
);
    import msg_stamp_pkg::*;

    logic [STAMP_W-1:0]             count;
    logic                           cap_any;
    buf_dir_e                       act_dir;
    logic [NUM_RX-1:0]              rx_cap;
    logic [NUM_TX-1:0]              tx_cap;
    logic [NUM_RX-1:0][STAMP_W-1:0] rx_stamp;
    logic [NUM_RX-1:0]              rx_valid;
    logic [NUM_TX-1:0][STAMP_W-1:0] tx_stamp;
    logic [NUM_TX-1:0]              tx_valid;
    logic                           wr_unused_sink;

    // The stamp registers have no write path; CPU writes end here.
    assign wr_unused_sink = cpu_wr_en | (|cpu_wr_data);

    stamp_counter #(.W(STAMP_W)) u_counter (
        .clk   (clk),
        .rst_n (rst_n),
        .tick  (bit_tick),
        .init  (init_mode),
        .count (count)
    );

    // Capture qualifier: a good end of frame with stamping enabled.
    assign cap_any = eof_pulse & eof_ok & stamp_en;
    assign act_dir = buf_dir_e'(act_is_tx);

    for (genvar g = 0; g < NUM_RX; g++) begin : g_rx_dec
        assign rx_cap[g] = cap_any && (act_dir == DIR_RX) && (act_idx == IDX_W'(g));
    end
    for (genvar g = 0; g < NUM_TX; g++) begin : g_tx_dec
        assign tx_cap[g] = cap_any && (act_dir == DIR_TX) && (act_idx == IDX_W'(g));
    end

    stamp_bank #(.N(NUM_RX), .W(STAMP_W)) u_rx_bank (
        .clk       (clk),
        .rst_n     (rst_n),
        .cap_vec   (rx_cap),
        .cap_value (count),
        .stamp_q   (rx_stamp),
        .valid_q   (rx_valid)
    );

    stamp_bank #(.N(NUM_TX), .W(STAMP_W)) u_tx_bank (
        .clk       (clk),
        .rst_n     (rst_n),
        .cap_vec   (tx_cap),
        .cap_value (count),
        .stamp_q   (tx_stamp),
        .valid_q   (tx_valid)
    );

    stamp_read_port #(
        .NUM_RX  (NUM_RX),
        .NUM_TX  (NUM_TX),
        .STAMP_W (STAMP_W),
        .IDX_W   (IDX_W),
        .BYTE_W  (BYTE_W)
    ) u_read (
        .rx_stamp (rx_stamp),
        .rx_valid (rx_valid),
        .tx_stamp (tx_stamp),
        .tx_valid (tx_valid),
        .tx_empty (tx_empty),
        .tx_sel   (tx_sel),
        .rd_is_tx (rd_is_tx),
        .rd_idx   (rd_idx),
        .rd_hi    (rd_hi),
        .rd_data  (rd_data)
    );

    assert_single_target_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({rx_cap, tx_cap}));

    assert_disabled_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !stamp_en |=> ($stable(rx_stamp) && $stable(tx_stamp)));

    assert_bad_frame_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !eof_ok |=> ($stable(rx_stamp) && $stable(tx_stamp)));

    assert_write_ignored_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_wr_en && !cap_any) |=> ($stable(rx_stamp) && $stable(tx_stamp)));

    assert_tx_gate_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_is_tx && ((tx_empty & tx_sel) == '0)) |-> (rd_data == '0));

    assert_rx_unwritten_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (!rd_is_tx && (rx_valid == '0)) |-> (rd_data == '0));

    assert_bad_index_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (!rd_is_tx && (int'(rd_idx) >= NUM_RX)) |-> (rd_data == '0));
endmodule

// File: tb/msg_stamp_unit_test.sv
`timescale 1ns/1ps
// Bench: a behavioural model (integers and arrays) is advanced on every
// clock. All sixteen read addresses are compared against it after each edge,
// and the bench adds hand-computed checks for wrap, byte order, init and
// same-clock capture.
module msg_stamp_unit_test;
    logic       clk = 1'b0;
    logic       rst_n;
    logic       bit_tick, init_mode, stamp_en, eof_pulse, eof_ok, act_is_tx;
    logic [1:0] act_idx;
    logic [2:0] tx_empty, tx_sel;
    logic       cpu_wr_en;
    logic [7:0] cpu_wr_data;
    logic       rd_is_tx, rd_hi;
    logic [1:0] rd_idx;
    logic [7:0] rd_data;

    int    n_chk  = 0;
    int    n_fail = 0;
    string cur_req = "R10";
    bit    done = 0;

    int m_cnt;
    int m_rx[3];
    int m_tx[3];
    bit m_rxv[3];
    bit m_txv[3];

    msg_stamp_unit uut (
        .clk(clk), .rst_n(rst_n), .bit_tick(bit_tick), .init_mode(init_mode),
        .stamp_en(stamp_en), .eof_pulse(eof_pulse), .eof_ok(eof_ok),
        .act_is_tx(act_is_tx), .act_idx(act_idx), .tx_empty(tx_empty),
        .tx_sel(tx_sel), .cpu_wr_en(cpu_wr_en), .cpu_wr_data(cpu_wr_data),
        .rd_is_tx(rd_is_tx), .rd_idx(rd_idx), .rd_hi(rd_hi), .rd_data(rd_data)
    );

    always #2.5 clk = ~clk;

    task automatic chk(string req, logic [7:0] got, int exp);
        n_chk++;
        if (got !== 8'(exp)) begin
            n_fail++;
            $display("FAIL %s got=%0h expected=%0h", req, got, exp);
        end
    endtask

    function automatic int exp_rd(bit tx, int idx, bit hi);
        int v;
        if (idx >= 3) return 0;
        if (tx) begin
            if (!(tx_empty[idx] && tx_sel[idx] && m_txv[idx])) return 0;
            v = m_tx[idx];
        end else begin
            if (!m_rxv[idx]) return 0;
            v = m_rx[idx];
        end
        return hi ? ((v >> 8) & 255) : (v & 255);
    endfunction

    // Model step from the inputs present at the clock edge.
    task automatic model_step();
        if (!rst_n) begin
            m_cnt = 0;
            for (int i = 0; i < 3; i++) begin
                m_rx[i] = 0; m_tx[i] = 0; m_rxv[i] = 0; m_txv[i] = 0;
            end
        end else begin
            if (eof_pulse && eof_ok && stamp_en && act_idx < 3) begin
                if (act_is_tx) begin m_tx[act_idx] = m_cnt; m_txv[act_idx] = 1; end
                else begin m_rx[act_idx] = m_cnt; m_rxv[act_idx] = 1; end
            end
            if (init_mode) m_cnt = 0;
            else if (bit_tick) m_cnt = (m_cnt + 1) & 16'hFFFF;
        end
    endtask

    task automatic sweep();
        for (int t = 0; t < 2; t++)
            for (int i = 0; i < 4; i++)
                for (int h = 0; h < 2; h++) begin
                    rd_is_tx = t[0]; rd_idx = 2'(i); rd_hi = h[0];
                    #0.05;
                    chk(cur_req, rd_data, exp_rd(t[0], i, h[0]));
                end
    endtask

    // One clock: update the model at the edge, compare, return at the falling edge.
    task automatic cyc();
        @(posedge clk);
        model_step();
        #0.2;
        sweep();
        @(negedge clk);
        eof_pulse = 0;
        cpu_wr_en = 0;
    endtask

    task automatic direct(bit tx, int idx, bit hi, output logic [7:0] v);
        rd_is_tx = tx; rd_idx = 2'(idx); rd_hi = hi;
        #0.1;
        v = rd_data;
    endtask

    task automatic capture(bit tx, int idx, bit tk);
        act_is_tx = tx; act_idx = 2'(idx); eof_pulse = 1; bit_tick = tk;
        cyc();
        bit_tick = 0;
    endtask

    task automatic clear_count();
        init_mode = 1; cyc(); init_mode = 0;
    endtask

    initial begin
        #(5.0 * 150000);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog expired");
            $display("  TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        logic [7:0] v;
        rst_n = 0; bit_tick = 0; init_mode = 0; stamp_en = 1; eof_pulse = 0;
        eof_ok = 1; act_is_tx = 0; act_idx = 0; tx_empty = 3'b111;
        tx_sel = 3'b001; cpu_wr_en = 0; cpu_wr_data = 0;
        rd_is_tx = 0; rd_idx = 0; rd_hi = 0;
        @(negedge clk);
        cur_req = "R10";                 // reset state: every read is zero
        repeat (3) cyc();
        rst_n = 1;
        cyc();

        cur_req = "R1";                  // mixed tick pattern, then capture
        for (int k = 0; k < 9; k++) begin bit_tick = (k % 3) != 1; cyc(); end
        bit_tick = 0;
        capture(0, 0, 0);

        cur_req = "R7";                  // tick and capture on the same clock
        clear_count();
        bit_tick = 1; repeat (4) cyc();
        capture(0, 1, 1);
        direct(0, 1, 0, v); chk("R7", v, 4);

        cur_req = "R4";                  // capture into each transmit buffer
        for (int i = 0; i < 3; i++) begin
            bit_tick = 1; repeat (i + 2) cyc();
            tx_sel = 3'(1 << i);
            capture(1, i, 0);
        end

        cur_req = "R9";                  // empty/select combinations
        for (int e = 0; e < 8; e++)
            for (int s = 0; s < 8; s++) begin
                tx_empty = 3'(e); tx_sel = 3'(s); cyc();
            end
        tx_empty = 3'b111; tx_sel = 3'b010;

        cur_req = "R5";                  // stamping disabled
        bit_tick = 1; cyc(); bit_tick = 0;
        stamp_en = 0;
        capture(0, 0, 0); capture(1, 1, 0);
        stamp_en = 1;

        cur_req = "R6";                  // bad frame
        eof_ok = 0;
        capture(0, 1, 0); capture(1, 1, 0);
        eof_ok = 1;

        cur_req = "R12";                 // index out of range
        capture(0, 3, 0); capture(1, 3, 0);

        cur_req = "R11";                 // CPU writes are dropped
        for (int k = 0; k < 6; k++) begin
            cpu_wr_en = 1; cpu_wr_data = 8'(8'hA5 + k);
            rd_is_tx = k[0]; rd_idx = 2'(k % 3);
            cyc();
        end

        cur_req = "R3";                  // init clears the counter
        bit_tick = 1; repeat (5) cyc();
        init_mode = 1; cyc(); init_mode = 0;
        repeat (2) cyc();
        bit_tick = 0;
        capture(0, 2, 0);
        direct(0, 2, 0, v); chk("R3", v, 2);

        cur_req = "R8";                  // byte order with 0x1234
        clear_count();
        bit_tick = 1; repeat (16'h1234) cyc(); bit_tick = 0;
        tx_sel = 3'b001;
        capture(1, 0, 0);
        direct(1, 0, 1, v); chk("R8", v, 8'h12);
        direct(1, 0, 0, v); chk("R8", v, 8'h34);

        cur_req = "R2";                  // counter wrap
        clear_count();
        bit_tick = 1; repeat (65539) cyc(); bit_tick = 0;
        capture(0, 2, 0);
        direct(0, 2, 0, v); chk("R2", v, 3);
        direct(0, 2, 1, v); chk("R2", v, 0);

        done = 1;
        $display("  TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
        $finish;
    end
endmodule